// File: doc/BRIEF.md
# Flash Erase and Suspend Command Sequencer

This block is the host-side sequencer for an asynchronous parallel NOR flash. Requests come in over a valid/ready port. There are four kinds: whole-array erase, suspend of the operation in progress, resume, and single-word read. The block turns each request into the bus write and read strobes the flash expects. Each strobe is one clock wide and comes from a register.

After the erase command sequence, the sequencer polls the status word. It declares the operation finished once two back-to-back status reads agree on both toggling bits. A suspend write stops the polling. The block then keeps the flash bus quiet for a fixed delay, set by parameters as clock frequency times a microsecond count. After that delay, reads are served, except reads to the sector named by the suspend request, which are refused. A single resume write restarts the polling.

Top module: `flash_erase_suspend_ctrl`

## Requirements
- R1: An erase request accepted while idle drives exactly six write strobes in six consecutive cycles, with (address, data) = (555h,AAh), (2AAh,55h), (555h,80h), (555h,AAh), (2AAh,55h), (555h,10h) in that order.
- R2: After the erase writes, the block issues status reads at address 0. `op_done` pulses high for one cycle only when two consecutive status reads show equal values in bit 6 and in bit 2. No pulse occurs while the flash still reports busy.
- R3: A suspend request is accepted only while an erase is being polled. It produces one write strobe with data B0h at the request address. The top `SECT_W` address bits of that address name the suspended sector.
- R4: After the suspend write, the bus carries no read or write strobe for `CLK_MHZ*SUSP_US` cycles, and `req_ready` stays low over that span.
- R5: A read request while idle, or while suspended to an address outside the suspended sector, produces one read strobe at that address. It then gives one `rsp_valid` pulse with the data read and `rsp_err`=0.
- R6: While suspended, a read request whose top `SECT_W` address bits equal the suspended sector is answered with `rsp_valid`=1 and `rsp_err`=1, and produces no bus strobe.
- R7: A resume request while suspended produces one write strobe with data 30h, and status polling restarts from a fresh comparison. A resume request at any other time is answered with `rsp_err`=1 and writes nothing.
- R8: A request not permitted in the current state is answered with `rsp_valid`=1 and `rsp_err`=1 and produces no bus strobe. Examples are suspend while idle, and erase or read during polling.
- R9: After reset, `fl_we`, `fl_re`, `op_done` and `rsp_valid` are low and `req_ready` is high. The write and read strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_op | input | 2 | 0 erase, 1 suspend, 2 resume, 3 read |
| req_addr | input | ADDR_W | Read address, or suspend/resume address |
| rsp_valid | output | 1 | One-cycle response pulse for reads and refused requests |
| rsp_err | output | 1 | Response is a refusal |
| rsp_data | output | DATA_W | Read data |
| op_done | output | 1 | One-cycle pulse when the erase completes |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_addr | output | ADDR_W | Flash address |
| fl_wdata | output | DATA_W | Flash write data |
| fl_rdata | input | DATA_W | Flash read data, valid while `fl_re` is high |

## Verification
Two functions can coincide in one cycle: the end of the post-suspend delay, and the acceptance of a read request that has been held waiting. The bench provokes this by raising a read to another sector straight after the suspend is accepted and holding it through the whole delay.

It then checks three things:
- the read strobe appears no fewer than `CLK_MHZ*SUSP_US` cycles after the B0h write, and only a few cycles past that bound;
- exactly one read strobe results;
- the returned data matches the flash model's value for that address.

// File: rtl/fes_pkg.sv
package fes_pkg;
  typedef enum logic [1:0] {
    OP_ERASE   = 2'd0,
    OP_SUSPEND = 2'd1,
    OP_RESUME  = 2'd2,
    OP_READ    = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CMD,
    ST_POLL_RD,
    ST_POLL_CAP,
    ST_POLL_GAP,
    ST_SUSP_WAIT,
    ST_SUSPENDED,
    ST_RD,
    ST_RD_CAP
  } st_e;
endpackage

// File: rtl/fes_cmd_rom.sv
module fes_cmd_rom #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int STEP_W = 3
) (
  input  logic [STEP_W-1:0] step,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  localparam logic [ADDR_W-1:0] KEY_A0 = ADDR_W'(16'h0555);
  localparam logic [ADDR_W-1:0] KEY_A1 = ADDR_W'(16'h02AA);

  always_comb begin
    addr = KEY_A0;
    data = DATA_W'(8'hAA);
    case (step)
      3'd0: begin addr = KEY_A0; data = DATA_W'(8'hAA); end
      3'd1: begin addr = KEY_A1; data = DATA_W'(8'h55); end
      3'd2: begin addr = KEY_A0; data = DATA_W'(8'h80); end
      3'd3: begin addr = KEY_A0; data = DATA_W'(8'hAA); end
      3'd4: begin addr = KEY_A1; data = DATA_W'(8'h55); end
      default: begin addr = KEY_A0; data = DATA_W'(8'h10); end
    endcase
  end
endmodule

// File: rtl/fes_wait_timer.sv
module fes_wait_timer #(
  parameter int CYCLES = 1500
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expire
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CW'(CYCLES);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expire = (cnt == CW'(1));
endmodule

// File: rtl/fes_toggle_chk.sv
module fes_toggle_chk (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       cap,
  input  logic [1:0] bits,
  output logic       settled
);
  logic [1:0] prev;
  logic       prev_vld;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      prev     <= '0;
      prev_vld <= 1'b0;
    end else if (cap) begin
      prev     <= bits;
      prev_vld <= 1'b1;
    end
  end

  assign settled = cap && prev_vld && (bits == prev);
endmodule

// File: rtl/flash_erase_suspend_ctrl.sv
module flash_erase_suspend_ctrl #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int SECT_W  = 4,
  parameter int CLK_MHZ = 100,
  parameter int SUSP_US = 15,
  parameter int TOG_HI  = 6,
  parameter int TOG_LO  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_data,
  output logic              op_done,
  output logic              fl_we,
  output logic              fl_re,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_wdata,
  input  logic [DATA_W-1:0] fl_rdata
);
  import fes_pkg::*;

  localparam int WAIT_CYC  = CLK_MHZ * SUSP_US;
  localparam int STEP_W    = 3;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(5);
  localparam logic [DATA_W-1:0] SUSP_CODE = DATA_W'(8'hB0);
  localparam logic [DATA_W-1:0] RES_CODE  = DATA_W'(8'h30);
  localparam logic [ADDR_W-1:0] POLL_ADDR = '0;

  st_e               state;
  op_e               op;
  logic [STEP_W-1:0] step;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_ret_susp;
  logic [SECT_W-1:0] susp_sect;
  logic [ADDR_W-1:0] rom_addr;
  logic [DATA_W-1:0] rom_data;
  logic              tmr_load;
  logic              tmr_expire;
  logic              tog_clr;
  logic              tog_cap;
  logic              tog_settled;
  logic [SECT_W-1:0] req_sect;

  assign op        = op_e'(req_op);
  assign req_sect  = req_addr[ADDR_W-1 -: SECT_W];
  assign req_ready = (state == ST_IDLE) || (state == ST_POLL_GAP) ||
                     (state == ST_SUSPENDED);

  assign tmr_load = (state == ST_POLL_GAP) && req_valid && (op == OP_SUSPEND);
  assign tog_cap  = (state == ST_POLL_CAP);
  assign tog_clr  = ((state == ST_CMD) && (step == LAST_STEP)) ||
                    ((state == ST_SUSPENDED) && req_valid && (op == OP_RESUME));

  fes_cmd_rom #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_W(STEP_W)
  ) u_rom (
    .step(step), .addr(rom_addr), .data(rom_data)
  );

  fes_wait_timer #(.CYCLES(WAIT_CYC)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .expire(tmr_expire)
  );

  fes_toggle_chk u_tog (
    .clk(clk), .rst(rst), .clr(tog_clr), .cap(tog_cap),
    .bits({fl_rdata[TOG_HI], fl_rdata[TOG_LO]}),
    .settled(tog_settled)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      step        <= '0;
      rd_addr     <= '0;
      rd_ret_susp <= 1'b0;
      susp_sect   <= '0;
      fl_we       <= 1'b0;
      fl_re       <= 1'b0;
      fl_addr     <= '0;
      fl_wdata    <= '0;
      rsp_valid   <= 1'b0;
      rsp_err     <= 1'b0;
      rsp_data    <= '0;
      op_done     <= 1'b0;
    end else begin
      fl_we     <= 1'b0;
      fl_re     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      op_done   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (op == OP_ERASE) begin
              step  <= '0;
              state <= ST_CMD;
            end else if (op == OP_READ) begin
              rd_addr     <= req_addr;
              rd_ret_susp <= 1'b0;
              state       <= ST_RD;
            end else begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b1;
            end
          end
        end
        ST_CMD: begin
          fl_we    <= 1'b1;
          fl_addr  <= rom_addr;
          fl_wdata <= rom_data;
          step     <= step + 1'b1;
          if (step == LAST_STEP) state <= ST_POLL_RD;
        end
        ST_POLL_RD: begin
          fl_re   <= 1'b1;
          fl_addr <= POLL_ADDR;
          state   <= ST_POLL_CAP;
        end
        ST_POLL_CAP: begin
          if (tog_settled) begin
            op_done <= 1'b1;
            state   <= ST_IDLE;
          end else begin
            state <= ST_POLL_GAP;
          end
        end
        ST_POLL_GAP: begin
          state <= ST_POLL_RD;
          if (req_valid) begin
            if (op == OP_SUSPEND) begin
              fl_we     <= 1'b1;
              fl_addr   <= req_addr;
              fl_wdata  <= SUSP_CODE;
              susp_sect <= req_sect;
              state     <= ST_SUSP_WAIT;
            end else begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b1;
            end
          end
        end
        ST_SUSP_WAIT: begin
          if (tmr_expire) state <= ST_SUSPENDED;
        end
        ST_SUSPENDED: begin
          if (req_valid) begin
            if (op == OP_READ && req_sect != susp_sect) begin
              rd_addr     <= req_addr;
              rd_ret_susp <= 1'b1;
              state       <= ST_RD;
            end else if (op == OP_RESUME) begin
              fl_we    <= 1'b1;
              fl_addr  <= req_addr;
              fl_wdata <= RES_CODE;
              state    <= ST_POLL_RD;
            end else begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b1;
            end
          end
        end
        ST_RD: begin
          fl_re   <= 1'b1;
          fl_addr <= rd_addr;
          state   <= ST_RD_CAP;
        end
        ST_RD_CAP: begin
          rsp_valid <= 1'b1;
          rsp_data  <= fl_rdata;
          state     <= rd_ret_susp ? ST_SUSPENDED : ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fes_checker.sv
module fes_checker #(
  parameter int DATA_W   = 8,
  parameter int WAIT_CYC = 1500
) (
  input logic              clk,
  input logic              rst,
  input logic              fl_we,
  input logic              fl_re,
  input logic [DATA_W-1:0] fl_wdata,
  input logic              op_done
);
  localparam int CW = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC + 1);

  logic [CW-1:0] quiet_cnt;
  logic          in_susp;

  always_ff @(posedge clk) begin
    if (rst) begin
      quiet_cnt <= '0;
      in_susp   <= 1'b0;
    end else begin
      if (fl_we && fl_wdata == DATA_W'(8'hB0)) begin
        quiet_cnt <= CW'(WAIT_CYC);
        in_susp   <= 1'b1;
      end else begin
        if (quiet_cnt != '0) quiet_cnt <= quiet_cnt - 1'b1;
        if (fl_we && fl_wdata == DATA_W'(8'h30)) in_susp <= 1'b0;
      end
    end
  end

  a_r4_bus_quiet: assert property (@(posedge clk) disable iff (rst)
    (quiet_cnt != '0) |-> (!fl_we && !fl_re));

  a_r7_resume_only_suspended: assert property (@(posedge clk) disable iff (rst)
    (fl_we && fl_wdata == DATA_W'(8'h30)) |-> in_susp);

  a_r2_done_bus_idle: assert property (@(posedge clk) disable iff (rst)
    op_done |-> (!fl_we && !fl_re));

  a_r9_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(fl_we && fl_re));

  a_r1_erase_code_in_run: assert property (@(posedge clk) disable iff (rst)
    (fl_we && fl_wdata == DATA_W'(8'h10)) |-> $past(fl_we));
endmodule

bind flash_erase_suspend_ctrl fes_checker #(
  .DATA_W(DATA_W), .WAIT_CYC(CLK_MHZ * SUSP_US)
) u_fes_checker (
  .clk(clk), .rst(rst), .fl_we(fl_we), .fl_re(fl_re),
  .fl_wdata(fl_wdata), .op_done(op_done)
);

// File: tb/flash_erase_suspend_ctrl_tb.sv
module flash_erase_suspend_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int SECT_W = 4;
  localparam int CLK_MHZ = 10;
  localparam int SUSP_US = 15;
  localparam int WAIT_CYC = CLK_MHZ * SUSP_US;
  localparam int BUSY_N = 12;
  localparam int LOG_N = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic rsp_valid, rsp_err, op_done, fl_we, fl_re;
  logic [DATA_W-1:0] rsp_data, fl_wdata, fl_rdata;
  logic [ADDR_W-1:0] fl_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_erase_suspend_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W),
    .CLK_MHZ(CLK_MHZ), .SUSP_US(SUSP_US)
  ) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_data(rsp_data), .op_done(op_done),
    .fl_we(fl_we), .fl_re(fl_re), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_rdata(fl_rdata)
  );

  // flash model
  logic m_busy = 1'b0, m_susp = 1'b0, m_tog = 1'b0;
  int   m_rem = 0;
  assign fl_rdata = (m_busy && !m_susp) ? {1'b0, m_tog, 3'b000, m_tog, 2'b00}
                                        : (fl_addr[7:0] ^ 8'hA5);
  always @(posedge clk) begin
    if (fl_we && fl_wdata == 8'h10) begin m_busy <= 1'b1; m_rem <= BUSY_N; end
    if (fl_we && fl_wdata == 8'hB0 && m_busy) m_susp <= 1'b1;
    if (fl_we && fl_wdata == 8'h30) m_susp <= 1'b0;
    if (fl_re && m_busy && !m_susp) begin
      m_tog <= ~m_tog;
      m_rem <= m_rem - 1;
      if (m_rem == 1) m_busy <= 1'b0;
    end
  end

  // bus monitor
  int cyc = 0, wr_n = 0, rd_cnt = 0, last_re_cyc = 0;
  int rsp_cnt = 0, done_cnt = 0, done_busy = 0;
  logic [ADDR_W-1:0] wr_addr [LOG_N];
  logic [DATA_W-1:0] wr_data [LOG_N];
  int wr_cyc [LOG_N];
  logic [DATA_W-1:0] last_rsp_data = '0;
  logic last_rsp_err = 1'b0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (fl_we && wr_n < LOG_N) begin
      wr_addr[wr_n] <= fl_addr; wr_data[wr_n] <= fl_wdata; wr_cyc[wr_n] <= cyc;
      wr_n <= wr_n + 1;
    end
    if (fl_re) begin rd_cnt <= rd_cnt + 1; last_re_cyc <= cyc; end
    if (rsp_valid) begin
      rsp_cnt <= rsp_cnt + 1; last_rsp_data <= rsp_data; last_rsp_err <= rsp_err;
    end
    if (op_done) begin done_cnt <= done_cnt + 1; done_busy <= int'(m_busy); end
  end

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
  endtask

  task automatic wait_rsp(input int base);
    for (int i = 0; i < 400 && rsp_cnt <= base; i++) @(negedge clk);
    #1;
  endtask

  task automatic wait_done(input int base);
    for (int i = 0; i < 2000 && done_cnt <= base; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(req_ready == 1'b1, "R9 ready after reset", int'(req_ready), 1);
    chk(!fl_we && !fl_re, "R9 strobes low after reset", int'({fl_we, fl_re}), 0);
    chk(!op_done && !rsp_valid, "R9 done/rsp low after reset", int'({op_done, rsp_valid}), 0);
  endtask

  task automatic t_idle_read();
    int s0 = rsp_cnt, r0 = rd_cnt;
    send(2'd3, 16'h1234);
    wait_rsp(s0);
    chk(rsp_cnt == s0 + 1 && !last_rsp_err, "R5 idle read answered", rsp_cnt - s0, 1);
    chk(last_rsp_data == (8'h34 ^ 8'hA5), "R5 idle read data", last_rsp_data, 8'h34 ^ 8'hA5);
    chk(rd_cnt == r0 + 1, "R5 one read strobe", rd_cnt - r0, 1);
  endtask

  task automatic t_illegal_idle();
    int s0 = rsp_cnt, w0 = wr_n;
    send(2'd1, 16'h2000);
    wait_rsp(s0);
    chk(last_rsp_err == 1'b1, "R8 suspend in idle refused", last_rsp_err, 1);
    s0 = rsp_cnt;
    send(2'd2, 16'h0000);
    wait_rsp(s0);
    chk(last_rsp_err == 1'b1, "R7 resume in idle refused", last_rsp_err, 1);
    chk(wr_n == w0, "R8 no write for refused", wr_n - w0, 0);
  endtask

  task automatic t_erase();
    int w0 = wr_n, r0 = rd_cnt, d0 = done_cnt;
    logic [ADDR_W-1:0] ea [6] = '{16'h555, 16'h2AA, 16'h555, 16'h555, 16'h2AA, 16'h555};
    logic [DATA_W-1:0] ed [6] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h10};
    bit ok = 1;
    send(2'd0, 16'h0000);
    wait_done(d0);
    chk(wr_n == w0 + 6, "R1 six writes", wr_n - w0, 6);
    for (int i = 0; i < 6; i++) begin
      if (wr_addr[w0+i] != ea[i] || wr_data[w0+i] != ed[i]) ok = 0;
      if (i > 0 && wr_cyc[w0+i] != wr_cyc[w0+i-1] + 1) ok = 0;
    end
    chk(ok, "R1 sequence and contiguity", int'(ok), 1);
    chk(done_cnt == d0 + 1, "R2 single done pulse", done_cnt - d0, 1);
    chk(done_busy == 0, "R2 done only after busy clear", done_busy, 0);
    chk(rd_cnt - r0 > BUSY_N, "R2 polled through busy", rd_cnt - r0, BUSY_N + 1);
  endtask

  task automatic t_suspend();
    int w0 = wr_n, r0 = rd_cnt, d0 = done_cnt, s0, wc, rr, n30;
    send(2'd0, 16'h0000);
    for (int i = 0; i < 200 && rd_cnt < r0 + 3; i++) @(negedge clk);
    send(2'd1, 16'h3000);
    chk(wr_data[wr_n-1] == 8'hB0 && wr_addr[wr_n-1] == 16'h3000,
        "R3 suspend write B0", wr_data[wr_n-1], 8'hB0);
    wc = wr_cyc[wr_n-1];
    rr = rd_cnt; s0 = rsp_cnt;
    send(2'd3, 16'h5077);
    wait_rsp(s0);
    chk(last_re_cyc - wc >= WAIT_CYC, "R4 no read before wait", last_re_cyc - wc, WAIT_CYC);
    chk(last_re_cyc - wc <= WAIT_CYC + 4, "R4 read soon after wait", last_re_cyc - wc, WAIT_CYC);
    chk(rd_cnt == rr + 1, "R5 suspended read one strobe", rd_cnt - rr, 1);
    chk(!last_rsp_err && last_rsp_data == (8'h77 ^ 8'hA5), "R5 suspended read data",
        last_rsp_data, 8'h77 ^ 8'hA5);
    rr = rd_cnt; s0 = rsp_cnt;
    send(2'd3, 16'h3010);
    wait_rsp(s0);
    repeat (3) @(negedge clk); #1;
    chk(last_rsp_err == 1'b1, "R6 sector read refused", last_rsp_err, 1);
    chk(rd_cnt == rr, "R6 no strobe for refused read", rd_cnt - rr, 0);
    send(2'd2, 16'h0000);
    chk(wr_data[wr_n-1] == 8'h30, "R7 resume write 30", wr_data[wr_n-1], 8'h30);
    s0 = rsp_cnt;
    send(2'd2, 16'h0000);
    wait_rsp(s0);
    chk(last_rsp_err == 1'b1, "R7 second resume refused", last_rsp_err, 1);
    s0 = rsp_cnt;
    send(2'd0, 16'h0000);
    wait_rsp(s0);
    chk(last_rsp_err == 1'b1, "R8 erase while polling refused", last_rsp_err, 1);
    wait_done(d0);
    n30 = 0;
    for (int i = w0; i < wr_n; i++) if (wr_data[i] == 8'h30) n30++;
    chk(n30 == 1, "R7 exactly one resume write", n30, 1);
    chk(done_cnt == d0 + 1 && done_busy == 0, "R2 done after resume", done_cnt - d0, 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_idle_read();
    t_illegal_idle();
    t_erase();
    t_suspend();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule